// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog for a small microcontroller bus. A counter advances on each cycle where a 4x bus-clock enable is high. If software does not service it in time, the counter reaches a chosen limit and the block sends a one-cycle system reset request. Software services the watchdog by writing to the highest address of the memory map, 0xFFFF. The write data does not matter. That same address is where the reset vector sits. A read of 0xFFFF therefore returns the low byte of the reset vector and never any watchdog state.

The counter is held cleared while a configuration disable bit is set or while the device is in monitor mode. In stop mode the counting clock is gated. The low prescaler bits of the counter are cleared during stop, and the upper bits keep their value. A separate stop-disable configuration bit turns an executed STOP instruction into an illegal-opcode reset request. The block raises no interrupts. Counting does not depend on whether the CPU is idling in wait mode.

Top module: `svc_watchdog`

## Requirements
- R1: A bus cycle with `bus_valid`=1, `bus_wr`=1 and `bus_addr`=0xFFFF clears the counter whatever else happens in that cycle. The next timeout then comes on the LIMIT-th later cycle that has `tick4x` high and no stop, clear or disable.
- R2: While `bus_valid`=1, `bus_wr`=0 and `bus_addr`=0xFFFF, `rd_data` equals `vec_lo` in the same cycle. For any other bus cycle, `rd_data` is 0. A read never changes the counter.
- R3: A write to any address other than 0xFFFF, or a write with `bus_valid`=0, does not clear the counter.
- R4: When `cfg_rate`=1, LIMIT is 2^SHORT_EXP − 2^PRE_BITS. When `cfg_rate`=0, LIMIT is 2^LONG_EXP − 2^PRE_BITS. The defaults give 8176 and 262128.
- R5: `wd_rst` is a registered pulse that lasts exactly one cycle. The counter returns to zero when the pulse is issued, so counting starts over.
- R6: While `cfg_dis`=1, the counter is held at zero and `wd_rst` stays low.
- R7: While `mon_mode`=1, the counter is held at zero and `wd_rst` stays low.
- R8: While `stop_mode`=1, the lowest PRE_BITS counter bits are cleared, the upper bits are held, and `wd_rst` stays low.
- R9: A cycle with `stop_exec`=1 and `cfg_stop_dis`=1 makes `illop_rst` high for exactly the next cycle. `stop_exec` with `cfg_stop_dis`=0 gives no `illop_rst`.
- R10: Synchronous `rst` clears the counter and drives `wd_rst` and `illop_rst` low.
- R11: The counter advances only on cycles where `tick4x`=1. A cycle without a tick never produces `wd_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick4x | input | 1 | 4x bus clock enable |
| bus_valid | input | 1 | Bus cycle is valid and completes |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bus address |
| vec_lo | input | DATA_W | Low byte of the reset vector, from ROM |
| cfg_dis | input | 1 | Configuration: watchdog disabled |
| cfg_rate | input | 1 | Configuration: 1 selects the short timeout |
| cfg_stop_dis | input | 1 | Configuration: STOP instruction is illegal |
| mon_mode | input | 1 | Monitor mode active |
| stop_mode | input | 1 | Device is in stop mode |
| stop_exec | input | 1 | A STOP instruction executes this cycle |
| rd_data | output | DATA_W | Read data for address 0xFFFF |
| wd_rst | output | 1 | Watchdog reset request pulse |
| illop_rst | output | 1 | Illegal-opcode reset request pulse |

## Verification
The single-pulse property of `wd_rst` relies on a LIMIT greater than one. The read-data property relies on `vec_lo` being steady while a read is in progress. The properties on the illegal-opcode request treat `stop_exec` as a strobe that is sampled on each cycle. They place no condition on its width.

The bench changes every input only at the falling clock edge. It holds `vec_lo` constant for the whole of each read. It uses small exponents so that both timeout lengths can be reached within a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_STOP  = 2'd2,
        CNT_RUN   = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic hit_wr;
        logic hit_rd;
    } bus_dec_t;

    function automatic int unsigned span(input int unsigned e, input int unsigned s);
        return (32'd1 << e) - (32'd1 << s);
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode import wdt_pkg::*; #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] vec_lo,
    output bus_dec_t          dec,
    output logic [DATA_W-1:0] rd_data
);
    logic match;

    always_comb begin
        match      = bus_valid && (bus_addr == SVC_ADDR);
        dec.hit_wr = match && bus_wr;
        dec.hit_rd = match && !bus_wr;
        rd_data    = dec.hit_rd ? vec_lo : '0;
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter import wdt_pkg::*; #(
    parameter int unsigned CNT_W     = 18,
    parameter int unsigned PRE_BITS  = 4,
    parameter int unsigned LIM_LONG  = 262128,
    parameter int unsigned LIM_SHORT = 8176
) (
    input  logic    clk,
    input  logic    rst,
    input  cnt_op_e op,
    input  logic    rate_short,
    output logic    fire
);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LIM_LONG - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LIM_SHORT - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb last = rate_short ? LAST_SHORT : LAST_LONG;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            case (op)
                CNT_CLEAR: cnt <= '0;
                CNT_STOP:  cnt[PRE_BITS-1:0] <= '0;
                CNT_RUN: begin
                    if (cnt >= last) begin
                        cnt  <= '0;
                        fire <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/wdt_stop_guard.sv
module wdt_stop_guard (
    input  logic clk,
    input  logic rst,
    input  logic stop_exec,
    input  logic stop_illegal,
    output logic illop
);
    always_ff @(posedge clk) begin
        if (rst) illop <= 1'b0;
        else     illop <= stop_exec && stop_illegal;
    end
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog import wdt_pkg::*; #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
    parameter int unsigned LONG_EXP  = 18,
    parameter int unsigned SHORT_EXP = 13,
    parameter int unsigned PRE_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick4x,
    input  logic              bus_valid,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] vec_lo,
    input  logic              cfg_dis,
    input  logic              cfg_rate,
    input  logic              cfg_stop_dis,
    input  logic              mon_mode,
    input  logic              stop_mode,
    input  logic              stop_exec,
    output logic [DATA_W-1:0] rd_data,
    output logic              wd_rst,
    output logic              illop_rst
);
    localparam int unsigned CNT_W     = LONG_EXP;
    localparam int unsigned LIM_LONG  = span(LONG_EXP, PRE_BITS);
    localparam int unsigned LIM_SHORT = span(SHORT_EXP, PRE_BITS);

    bus_dec_t dec;
    cnt_op_e  op;

    wdt_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)
    ) u_dec (
        .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .vec_lo(vec_lo), .dec(dec), .rd_data(rd_data)
    );

    always_comb begin
        if (cfg_dis || mon_mode) op = CNT_CLEAR;
        else if (dec.hit_wr)     op = CNT_CLEAR;
        else if (stop_mode)      op = CNT_STOP;
        else if (tick4x)         op = CNT_RUN;
        else                     op = CNT_HOLD;
    end

    wdt_counter #(
        .CNT_W(CNT_W), .PRE_BITS(PRE_BITS),
        .LIM_LONG(LIM_LONG), .LIM_SHORT(LIM_SHORT)
    ) u_cnt (
        .clk(clk), .rst(rst), .op(op), .rate_short(cfg_rate), .fire(wd_rst)
    );

    wdt_stop_guard u_stop (
        .clk(clk), .rst(rst), .stop_exec(stop_exec),
        .stop_illegal(cfg_stop_dis), .illop(illop_rst)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              tick4x,
    input logic              bus_valid,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] vec_lo,
    input logic              cfg_dis,
    input logic              cfg_stop_dis,
    input logic              mon_mode,
    input logic              stop_mode,
    input logic              stop_exec,
    input logic [DATA_W-1:0] rd_data,
    input logic              wd_rst,
    input logic              illop_rst
);
    logic svc_wr, svc_rd;
    assign svc_wr = bus_valid && bus_wr && (bus_addr == SVC_ADDR);
    assign svc_rd = bus_valid && !bus_wr && (bus_addr == SVC_ADDR);

    AST_SERVICE_RESTARTS: assert property (@(posedge clk) disable iff (rst) svc_wr |=> !wd_rst); // R1
    AST_READ_VECTOR: assert property (@(posedge clk) disable iff (rst) svc_rd |-> rd_data == vec_lo); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) wd_rst |=> !wd_rst); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) cfg_dis |=> !wd_rst); // R6
    AST_QUIET_IN_MONITOR: assert property (@(posedge clk) disable iff (rst) mon_mode |=> !wd_rst); // R7
    AST_QUIET_IN_STOP: assert property (@(posedge clk) disable iff (rst) stop_mode |=> !wd_rst); // R8
    AST_ILLOP_ON_STOP: assert property (@(posedge clk) disable iff (rst) (stop_exec && cfg_stop_dis) |=> illop_rst); // R9
    AST_ILLOP_ONLY_ON_STOP: assert property (@(posedge clk) disable iff (rst) !(stop_exec && cfg_stop_dis) |=> !illop_rst); // R9
    AST_NO_TICK_NO_FIRE: assert property (@(posedge clk) disable iff (rst) !tick4x |=> !wd_rst); // R11
endmodule

bind svc_watchdog wdt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)
) u_wdt_chk (
    .clk(clk), .rst(rst), .tick4x(tick4x), .bus_valid(bus_valid),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .vec_lo(vec_lo),
    .cfg_dis(cfg_dis), .cfg_stop_dis(cfg_stop_dis), .mon_mode(mon_mode),
    .stop_mode(stop_mode), .stop_exec(stop_exec), .rd_data(rd_data),
    .wd_rst(wd_rst), .illop_rst(illop_rst)
);

// File: tb/test_svc_watchdog.sv
`timescale 1ns/1ps
module test_svc_watchdog;
    localparam int unsigned LONG_EXP  = 9;
    localparam int unsigned SHORT_EXP = 6;
    localparam int unsigned PRE_BITS  = 4;
    localparam int LIM_L = (1 << LONG_EXP) - (1 << PRE_BITS);   // 496
    localparam int LIM_S = (1 << SHORT_EXP) - (1 << PRE_BITS);  // 48

    // {cfg_dis, mon_mode, cfg_rate, ticks[15:0], expect_fire}
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 16'(LIM_S - 1), 1'b0},
        {1'b0, 1'b0, 1'b1, 16'(LIM_S),     1'b1},
        {1'b0, 1'b0, 1'b0, 16'(LIM_L - 1), 1'b0},
        {1'b0, 1'b0, 1'b0, 16'(LIM_L),     1'b1},
        {1'b1, 1'b0, 1'b1, 16'd100,        1'b0},
        {1'b0, 1'b1, 1'b1, 16'd100,        1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick4x = 1'b0, bus_valid = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  vec_lo = 8'h00;
    logic cfg_dis = 1'b0, cfg_rate = 1'b1, cfg_stop_dis = 1'b0;
    logic mon_mode = 1'b0, stop_mode = 1'b0, stop_exec = 1'b0;
    logic [7:0] rd_data;
    logic wd_rst, illop_rst;

    int checks = 0;
    int errors = 0;
    logic seen;

    always #4 clk = ~clk;

    svc_watchdog #(
        .LONG_EXP(LONG_EXP), .SHORT_EXP(SHORT_EXP), .PRE_BITS(PRE_BITS)
    ) i_svc_watchdog (
        .clk(clk), .rst(rst), .tick4x(tick4x), .bus_valid(bus_valid),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .vec_lo(vec_lo),
        .cfg_dis(cfg_dis), .cfg_rate(cfg_rate), .cfg_stop_dis(cfg_stop_dis),
        .mon_mode(mon_mode), .stop_mode(stop_mode), .stop_exec(stop_exec),
        .rd_data(rd_data), .wd_rst(wd_rst), .illop_rst(illop_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic service();
        @(negedge clk);
        tick4x = 1'b0; bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 16'hFFFF;
        @(negedge clk);
        bus_valid = 1'b0; bus_wr = 1'b0; bus_addr = 16'h0;
    endtask

    task automatic run(input int n, output logic hit);
        hit = 1'b0;
        tick4x = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            hit = hit | wd_rst;
        end
        tick4x = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(wd_rst == 1'b0 && illop_rst == 1'b0, "R10 reset outputs", {wd_rst, illop_rst}, 0);

        // table walk: R4 lengths, R6 disable, R7 monitor
        for (int i = 0; i < 6; i++) begin
            cfg_dis = 1'b0; mon_mode = 1'b0; cfg_rate = VEC[i][17];
            service();
            cfg_dis = VEC[i][19]; mon_mode = VEC[i][18];
            run(int'(VEC[i][16:1]), seen);
            chk(seen == VEC[i][0], "R4/R6/R7 vector", seen, VEC[i][0]);
            cfg_dis = 1'b0; mon_mode = 1'b0;
        end

        cfg_rate = 1'b1;
        // R5: one-cycle pulse, counter restarts after firing
        service(); run(LIM_S, seen);
        @(negedge clk);
        chk(wd_rst == 1'b0, "R5 pulse width", wd_rst, 0);
        run(LIM_S - 1, seen); chk(!seen, "R5 restart early", seen, 0);
        run(1, seen);         chk(seen,  "R5 restart fire", seen, 1);

        // R1: service mid-count restarts
        service(); run(40, seen); service();
        run(LIM_S - 1, seen); chk(!seen, "R1 service restart early", seen, 0);
        run(1, seen);         chk(seen,  "R1 service restart fire", seen, 1);

        // R2: read returns vector byte, no effect on counter
        service(); run(40, seen);
        @(negedge clk);
        vec_lo = 8'hA5; bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = 16'hFFFF;
        #1 chk(rd_data == 8'hA5, "R2 read vector", rd_data, 8'hA5);
        @(negedge clk);
        bus_addr = 16'hFFFE;
        #1 chk(rd_data == 8'h00, "R2 other address", rd_data, 0);
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 16'h0;
        run(LIM_S - 41, seen); chk(!seen, "R2 read no clear early", seen, 0);
        run(1, seen);          chk(seen,  "R2 read no clear fire", seen, 1);

        // R3: wrong address / invalid cycle do not clear
        service(); run(40, seen);
        @(negedge clk);
        bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 16'hFFFE;
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 16'hFFFF;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0;
        run(LIM_S - 41, seen); chk(!seen, "R3 no clear early", seen, 0);
        run(1, seen);          chk(seen,  "R3 no clear fire", seen, 1);

        // R11: no tick, no advance
        service();
        repeat (100) @(negedge clk);
        chk(wd_rst == 1'b0, "R11 idle no fire", wd_rst, 0);
        run(LIM_S - 1, seen); chk(!seen, "R11 gap early", seen, 0);
        run(1, seen);         chk(seen,  "R11 gap fire", seen, 1);

        // R8: stop clears low bits (20 -> 16), holds upper bits
        service(); run(20, seen);
        stop_mode = 1'b1; tick4x = 1'b1;
        seen = 1'b0;
        repeat (5) begin @(negedge clk); seen = seen | wd_rst; end
        stop_mode = 1'b0; tick4x = 1'b0;
        chk(!seen, "R8 quiet in stop", seen, 0);
        run(LIM_S - 17, seen); chk(!seen, "R8 after stop early", seen, 0);
        run(1, seen);          chk(seen,  "R8 after stop fire", seen, 1);

        // R6: disable clears a running count
        service(); run(40, seen);
        cfg_dis = 1'b1; run(5, seen); cfg_dis = 1'b0;
        chk(!seen, "R6 quiet disabled", seen, 0);
        run(LIM_S - 1, seen); chk(!seen, "R6 cleared early", seen, 0);
        run(1, seen);         chk(seen,  "R6 cleared fire", seen, 1);

        // R10: reset mid-count clears counter
        service(); run(40, seen);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        run(LIM_S - 1, seen); chk(!seen, "R10 reset clears early", seen, 0);
        run(1, seen);         chk(seen,  "R10 reset clears fire", seen, 1);

        // R9: illegal stop
        @(negedge clk); cfg_stop_dis = 1'b1; stop_exec = 1'b1;
        @(negedge clk); stop_exec = 1'b0;
        chk(illop_rst == 1'b1, "R9 illop raised", illop_rst, 1);
        @(negedge clk);
        chk(illop_rst == 1'b0, "R9 illop one cycle", illop_rst, 0);
        cfg_stop_dis = 1'b0; stop_exec = 1'b1;
        @(negedge clk); stop_exec = 1'b0;
        chk(illop_rst == 1'b0, "R9 stop allowed", illop_rst, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule